// File: doc/BRIEF.md
# Programmable TFT Panel Timing Generator

This block drives the control side of a synchronous active-matrix TFT panel. It puts out a pixel clock, a horizontal sync, a vertical sync, a data-enable strobe and an output-only pixel data bus. A horizontal counter runs once per internal clock and wraps at a programmable line length. A vertical counter steps on each wrap and wraps at a programmable frame height. The point where both counters are zero at the start of a line is the local start point. Every control edge is measured from it in whole internal clock cycles.

Each control has its own offset, rise and fall settings, so it is not tied to fixed porch fields. Horizontal sync and the horizontal part of data enable are windows within a line, placed at offset plus rise and offset plus fall. Vertical sync starts on a programmed line and stops on another, both at the same cycle offset within the line. Pixel data keeps a fixed position relative to the start point and is forced to zero outside the enable window. Each output has its own polarity bit. The timing set is captured when the generator starts and again at each frame wrap, so one frame never mixes two settings.

Top module: `tft_timing_gen`

## Requirements
- R1: While running, the horizontal counter steps by one per clock from 0 to cfgHTotal-1 and then returns to 0. At each horizontal wrap the line counter steps, and it returns to 0 after line cfgVTotal-1.
- R2: Horizontal sync is active for line cycles c with hsOffset+hsUp <= c < hsOffset+hsDown. Each output shows, one clock edge later, the counter state it was computed from.
- R3: Take the frame position as line*hTotal+cycle. Vertical sync is active from position vsUp*hTotal+vsOffset up to, but not including, vsDown*hTotal+vsOffset.
- R4: Data enable is active when the line cycle lies in [deOffset+deUp, deOffset+deDown) and the line lies in [deFirstLine, deLastLine).
- R5: pixOut carries the pixIn value sampled at the same edge that makes data enable active, and is 0 whenever data enable is inactive. No offset setting moves the data.
- R6: cfgPolarity bit 1 sets horizontal sync, bit 2 vertical sync and bit 3 data enable, with 1 meaning active-high and 0 meaning active-low. Bit 0 = 0 makes pixClk follow the internal clock, so the panel samples on its falling edge. Bit 0 = 1 inverts pixClk.
- R7: While running, pixClk toggles on every internal clock phase. When not running, it holds the level of polarity bit 0.
- R8: The timing set and polarity are captured at start and at the frame wrap (last cycle of the last line). A change at any other time has no effect on the outputs until the next frame.
- R9: During and after reset, until enable is set, all controls are at their inactive level (low for the reset polarity), pixOut is 0 and pixClk is low. When enable drops, the run state clears at the next edge and the outputs go idle one edge after that.
- R10: For a setting in which horizontal sync lies inside the vertical sync span, every vertical sync pulse contains at least one horizontal sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; one count per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low returns the block to idle |
| cfgHTotal | input | H_W | Line length in clocks |
| cfgVTotal | input | V_W | Frame height in lines |
| cfgHsOffset | input | H_W | Horizontal sync offset |
| cfgHsUp | input | H_W | Horizontal sync assert distance from offset |
| cfgHsDown | input | H_W | Horizontal sync deassert distance from offset |
| cfgVsOffset | input | H_W | Cycle within the line where vertical sync changes |
| cfgVsUp | input | V_W | Line where vertical sync asserts |
| cfgVsDown | input | V_W | Line where vertical sync deasserts |
| cfgDeOffset | input | H_W | Data-enable offset |
| cfgDeUp | input | H_W | Data-enable assert distance from offset |
| cfgDeDown | input | H_W | Data-enable deassert distance from offset |
| cfgDeFirstLine | input | V_W | First line with data enable |
| cfgDeLastLine | input | V_W | Line after the last line with data enable |
| cfgPolarity | input | 4 | Polarity bits: clock, hsync, vsync, enable |
| pixIn | input | D_W | Pixel data from the source |
| pixClk | output | 1 | Pixel clock to the panel |
| hsyncOut | output | 1 | Horizontal sync |
| vsyncOut | output | 1 | Vertical sync |
| deOut | output | 1 | Data enable |
| pixOut | output | D_W | Gated pixel data |

## Verification
The bench builds the generator with an 8-bit horizontal counter, a 6-bit line counter and 8-bit pixel data. These widths allow frames of about a hundred cycles, so several frame wraps fit in one run. A reconfiguration in the middle of a frame can therefore be followed to the boundary where it takes effect, with active-low polarities and an inverted pixel clock. A second, shorter geometry after a stop and restart checks that windows clipped by the line end and vertical sync spanning lines behave the same at other sizes.

// File: rtl/tft_timing_pkg.sv
package tft_timing_pkg;

  // bit positions inside the polarity vector
  localparam int POL_CLK = 0;
  localparam int POL_HS  = 1;
  localparam int POL_VS  = 2;
  localparam int POL_DE  = 3;

  // polarity in force before the first start: syncs and enable active-high
  localparam logic [3:0] POL_RESET = 4'b1110;

  // horizontal windows built by the datapath
  localparam int WIN_HS  = 0;
  localparam int WIN_DE  = 1;
  localparam int NUM_WIN = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic deLine;
  } tftStrobe_t;

endpackage

// File: rtl/tft_timing_ctrl.sv
module tft_timing_ctrl
  import tft_timing_pkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [H_W-1:0] cfgHTotal,
  input  logic [V_W-1:0] cfgVTotal,
  input  logic [H_W-1:0] cfgHsOffset,
  input  logic [H_W-1:0] cfgHsUp,
  input  logic [H_W-1:0] cfgHsDown,
  input  logic [H_W-1:0] cfgVsOffset,
  input  logic [V_W-1:0] cfgVsUp,
  input  logic [V_W-1:0] cfgVsDown,
  input  logic [H_W-1:0] cfgDeOffset,
  input  logic [H_W-1:0] cfgDeUp,
  input  logic [H_W-1:0] cfgDeDown,
  input  logic [V_W-1:0] cfgDeFirstLine,
  input  logic [V_W-1:0] cfgDeLastLine,
  input  logic [3:0]     cfgPolarity,
  output logic [H_W-1:0] hCnt,
  output logic [V_W-1:0] vCnt,
  output logic [H_W-1:0] shHTotal,
  output logic [V_W-1:0] shVTotal,
  output logic [H_W-1:0] shHsOffset,
  output logic [H_W-1:0] shHsUp,
  output logic [H_W-1:0] shHsDown,
  output logic [H_W-1:0] shVsOffset,
  output logic [V_W-1:0] shVsUp,
  output logic [V_W-1:0] shVsDown,
  output logic [H_W-1:0] shDeOffset,
  output logic [H_W-1:0] shDeUp,
  output logic [H_W-1:0] shDeDown,
  output logic [3:0]     shPolarity,
  output tftStrobe_t     strb
);

  typedef struct packed {
    logic [H_W-1:0] hTotal;
    logic [V_W-1:0] vTotal;
    logic [H_W-1:0] hsOffset;
    logic [H_W-1:0] hsUp;
    logic [H_W-1:0] hsDown;
    logic [H_W-1:0] vsOffset;
    logic [V_W-1:0] vsUp;
    logic [V_W-1:0] vsDown;
    logic [H_W-1:0] deOffset;
    logic [H_W-1:0] deUp;
    logic [H_W-1:0] deDown;
    logic [V_W-1:0] deFirst;
    logic [V_W-1:0] deLast;
    logic [3:0]     polarity;
  } timingSet_t;

  localparam logic [H_W-1:0] H_ONE = {{(H_W-1){1'b0}}, 1'b1};
  localparam logic [V_W-1:0] V_ONE = {{(V_W-1){1'b0}}, 1'b1};

  timingSet_t cfgNow;
  timingSet_t shadow;
  logic       running;
  logic       lineEnd;
  logic       frameEnd;

  assign cfgNow = '{
    hTotal:   cfgHTotal,
    vTotal:   cfgVTotal,
    hsOffset: cfgHsOffset,
    hsUp:     cfgHsUp,
    hsDown:   cfgHsDown,
    vsOffset: cfgVsOffset,
    vsUp:     cfgVsUp,
    vsDown:   cfgVsDown,
    deOffset: cfgDeOffset,
    deUp:     cfgDeUp,
    deDown:   cfgDeDown,
    deFirst:  cfgDeFirstLine,
    deLast:   cfgDeLastLine,
    polarity: cfgPolarity
  };

  assign lineEnd  = (hCnt == shadow.hTotal - H_ONE);
  assign frameEnd = lineEnd && (vCnt == shadow.vTotal - V_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running         <= 1'b0;
      hCnt            <= '0;
      vCnt            <= '0;
      shadow          <= '0;
      shadow.polarity <= POL_RESET;
    end else if (!enable) begin
      running <= 1'b0;
      hCnt    <= '0;
      vCnt    <= '0;
    end else if (!running) begin
      running <= 1'b1;
      hCnt    <= '0;
      vCnt    <= '0;
      shadow  <= cfgNow;
    end else if (lineEnd) begin
      hCnt <= '0;
      if (frameEnd) begin
        vCnt   <= '0;
        shadow <= cfgNow;
      end else begin
        vCnt <= vCnt + V_ONE;
      end
    end else begin
      hCnt <= hCnt + H_ONE;
    end
  end

  assign strb.run    = running;
  assign strb.deLine = (vCnt >= shadow.deFirst) && (vCnt < shadow.deLast);

  assign shHTotal   = shadow.hTotal;
  assign shVTotal   = shadow.vTotal;
  assign shHsOffset = shadow.hsOffset;
  assign shHsUp     = shadow.hsUp;
  assign shHsDown   = shadow.hsDown;
  assign shVsOffset = shadow.vsOffset;
  assign shVsUp     = shadow.vsUp;
  assign shVsDown   = shadow.vsDown;
  assign shDeOffset = shadow.deOffset;
  assign shDeUp     = shadow.deUp;
  assign shDeDown   = shadow.deDown;
  assign shPolarity = shadow.polarity;

endmodule

// File: rtl/tft_timing_dp.sv
module tft_timing_dp
  import tft_timing_pkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 11,
  parameter int D_W = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  tftStrobe_t     strb,
  input  logic [H_W-1:0] hCnt,
  input  logic [V_W-1:0] vCnt,
  input  logic [H_W-1:0] hsOffset,
  input  logic [H_W-1:0] hsUp,
  input  logic [H_W-1:0] hsDown,
  input  logic [H_W-1:0] vsOffset,
  input  logic [V_W-1:0] vsUp,
  input  logic [V_W-1:0] vsDown,
  input  logic [H_W-1:0] deOffset,
  input  logic [H_W-1:0] deUp,
  input  logic [H_W-1:0] deDown,
  input  logic [3:0]     polarity,
  input  logic [D_W-1:0] pixIn,
  output logic           pixClk,
  output logic           hsyncOut,
  output logic           vsyncOut,
  output logic           deOut,
  output logic [D_W-1:0] pixOut,
  output logic           runQ,
  output logic [3:0]     polQ
);

  localparam int SUM_W = H_W + 1;

  logic [H_W-1:0]     winOff  [NUM_WIN];
  logic [H_W-1:0]     winUp   [NUM_WIN];
  logic [H_W-1:0]     winDown [NUM_WIN];
  logic [NUM_WIN-1:0] winAct;

  assign winOff[WIN_HS]  = hsOffset;
  assign winUp[WIN_HS]   = hsUp;
  assign winDown[WIN_HS] = hsDown;
  assign winOff[WIN_DE]  = deOffset;
  assign winUp[WIN_DE]   = deUp;
  assign winDown[WIN_DE] = deDown;

  // one horizontal window per control, extra bit keeps offset+distance exact
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic [SUM_W-1:0] riseAt;
    logic [SUM_W-1:0] fallAt;
    assign riseAt    = {1'b0, winOff[g]} + {1'b0, winUp[g]};
    assign fallAt    = {1'b0, winOff[g]} + {1'b0, winDown[g]};
    assign winAct[g] = ({1'b0, hCnt} >= riseAt) && ({1'b0, hCnt} < fallAt);
  end

  logic vsPastStart;
  logic vsBeforeEnd;
  logic hsAct;
  logic vsAct;
  logic deAct;

  assign vsPastStart = (vCnt > vsUp)   || ((vCnt == vsUp)   && (hCnt >= vsOffset));
  assign vsBeforeEnd = (vCnt < vsDown) || ((vCnt == vsDown) && (hCnt <  vsOffset));

  assign hsAct = strb.run && winAct[WIN_HS];
  assign vsAct = strb.run && vsPastStart && vsBeforeEnd;
  assign deAct = strb.run && winAct[WIN_DE] && strb.deLine;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runQ     <= 1'b0;
      polQ     <= POL_RESET;
      hsyncOut <= 1'b0;
      vsyncOut <= 1'b0;
      deOut    <= 1'b0;
      pixOut   <= '0;
    end else begin
      runQ     <= strb.run;
      polQ     <= polarity;
      hsyncOut <= ~(hsAct ^ polarity[POL_HS]);
      vsyncOut <= ~(vsAct ^ polarity[POL_VS]);
      deOut    <= ~(deAct ^ polarity[POL_DE]);
      pixOut   <= deAct ? pixIn : '0;
    end
  end

  assign pixClk = runQ ? (clk ^ polQ[POL_CLK]) : polQ[POL_CLK];

endmodule

// File: rtl/tft_timing_gen.sv
module tft_timing_gen
  import tft_timing_pkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 11,
  parameter int D_W = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [H_W-1:0] cfgHTotal,
  input  logic [V_W-1:0] cfgVTotal,
  input  logic [H_W-1:0] cfgHsOffset,
  input  logic [H_W-1:0] cfgHsUp,
  input  logic [H_W-1:0] cfgHsDown,
  input  logic [H_W-1:0] cfgVsOffset,
  input  logic [V_W-1:0] cfgVsUp,
  input  logic [V_W-1:0] cfgVsDown,
  input  logic [H_W-1:0] cfgDeOffset,
  input  logic [H_W-1:0] cfgDeUp,
  input  logic [H_W-1:0] cfgDeDown,
  input  logic [V_W-1:0] cfgDeFirstLine,
  input  logic [V_W-1:0] cfgDeLastLine,
  input  logic [3:0]     cfgPolarity,
  input  logic [D_W-1:0] pixIn,
  output logic           pixClk,
  output logic           hsyncOut,
  output logic           vsyncOut,
  output logic           deOut,
  output logic [D_W-1:0] pixOut
);

  tftStrobe_t     strb;
  logic [H_W-1:0] hCnt;
  logic [V_W-1:0] vCnt;
  logic [H_W-1:0] shHTotal, shHsOffset, shHsUp, shHsDown, shVsOffset;
  logic [H_W-1:0] shDeOffset, shDeUp, shDeDown;
  logic [V_W-1:0] shVTotal, shVsUp, shVsDown;
  logic [3:0]     shPolarity;
  logic           runQ;
  logic [3:0]     polQ;

  tft_timing_ctrl #(.H_W(H_W), .V_W(V_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable         (enable),
    .cfgHTotal      (cfgHTotal),
    .cfgVTotal      (cfgVTotal),
    .cfgHsOffset    (cfgHsOffset),
    .cfgHsUp        (cfgHsUp),
    .cfgHsDown      (cfgHsDown),
    .cfgVsOffset    (cfgVsOffset),
    .cfgVsUp        (cfgVsUp),
    .cfgVsDown      (cfgVsDown),
    .cfgDeOffset    (cfgDeOffset),
    .cfgDeUp        (cfgDeUp),
    .cfgDeDown      (cfgDeDown),
    .cfgDeFirstLine (cfgDeFirstLine),
    .cfgDeLastLine  (cfgDeLastLine),
    .cfgPolarity    (cfgPolarity),
    .hCnt           (hCnt),
    .vCnt           (vCnt),
    .shHTotal       (shHTotal),
    .shVTotal       (shVTotal),
    .shHsOffset     (shHsOffset),
    .shHsUp         (shHsUp),
    .shHsDown       (shHsDown),
    .shVsOffset     (shVsOffset),
    .shVsUp         (shVsUp),
    .shVsDown       (shVsDown),
    .shDeOffset     (shDeOffset),
    .shDeUp         (shDeUp),
    .shDeDown       (shDeDown),
    .shPolarity     (shPolarity),
    .strb           (strb)
  );

  tft_timing_dp #(.H_W(H_W), .V_W(V_W), .D_W(D_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .hCnt     (hCnt),
    .vCnt     (vCnt),
    .hsOffset (shHsOffset),
    .hsUp     (shHsUp),
    .hsDown   (shHsDown),
    .vsOffset (shVsOffset),
    .vsUp     (shVsUp),
    .vsDown   (shVsDown),
    .deOffset (shDeOffset),
    .deUp     (shDeUp),
    .deDown   (shDeDown),
    .polarity (shPolarity),
    .pixIn    (pixIn),
    .pixClk   (pixClk),
    .hsyncOut (hsyncOut),
    .vsyncOut (vsyncOut),
    .deOut    (deOut),
    .pixOut   (pixOut),
    .runQ     (runQ),
    .polQ     (polQ)
  );

endmodule

// File: rtl/tft_timing_gen_chk.sv
module tft_timing_gen_chk #(
  parameter int H_W = 12,
  parameter int V_W = 11,
  parameter int D_W = 24
) (
  input logic           clk,
  input logic           rst_n,
  input logic           enable,
  input logic           run,
  input logic [H_W-1:0] hCnt,
  input logic [V_W-1:0] vCnt,
  input logic [H_W-1:0] hTot,
  input logic [V_W-1:0] vTot,
  input logic [3:0]     shPol,
  input logic           runQ,
  input logic [3:0]     polQ,
  input logic           hsyncOut,
  input logic           vsyncOut,
  input logic           deOut,
  input logic [D_W-1:0] pixOut
);

  localparam logic [H_W-1:0] H_ONE = {{(H_W-1){1'b0}}, 1'b1};
  localparam logic [V_W-1:0] V_ONE = {{(V_W-1){1'b0}}, 1'b1};

  logic atLineEnd, atFrameEnd;
  logic hsOn, vsOn, vsOnQ, hsSeen;

  assign atLineEnd  = (hCnt == hTot - H_ONE);
  assign atFrameEnd = atLineEnd && (vCnt == vTot - V_ONE);
  assign hsOn = (hsyncOut == polQ[1]);
  assign vsOn = (vsyncOut == polQ[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsOnQ  <= 1'b0;
      hsSeen <= 1'b0;
    end else begin
      vsOnQ  <= vsOn;
      hsSeen <= vsOn ? (hsSeen | hsOn) : 1'b0;
    end
  end

  // R1: counter wraps at the line length
  p_line_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && enable && atLineEnd) |=> (hCnt == '0));

  // R1: counter steps by one inside a line
  p_line_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && enable && !atLineEnd) |=> (hCnt == $past(hCnt) + H_ONE));

  // R1: line counter steps on a wrap that is not the last line
  p_frame_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && enable && atLineEnd && !atFrameEnd) |=> (vCnt == $past(vCnt) + V_ONE));

  // R8: timing set is held everywhere except at the frame wrap
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && enable && !atFrameEnd) |=> ($stable(hTot) && $stable(vTot) && $stable(shPol)));

  // R5: no data outside the enable window
  p_data_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (deOut != polQ[3]) |-> (pixOut == '0));

  // R9: idle state drives every control to its inactive level
  p_idle_inactive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ((hsyncOut != polQ[1]) && (vsyncOut != polQ[2]) && (deOut != polQ[3]) && !runQ));

  // R10: a vertical sync pulse that ends by timing has enclosed a horizontal sync
  p_vs_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (runQ && vsOnQ && !vsOn) |-> hsSeen);

endmodule

bind tft_timing_gen tft_timing_gen_chk #(.H_W(H_W), .V_W(V_W), .D_W(D_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .run      (strb.run),
  .hCnt     (hCnt),
  .vCnt     (vCnt),
  .hTot     (shHTotal),
  .vTot     (shVTotal),
  .shPol    (shPolarity),
  .runQ     (runQ),
  .polQ     (polQ),
  .hsyncOut (hsyncOut),
  .vsyncOut (vsyncOut),
  .deOut    (deOut),
  .pixOut   (pixOut)
);

// File: tb/tft_timing_gen_bench.sv
`timescale 1ns/1ps
module tft_timing_gen_bench;

  localparam int H_W = 8;
  localparam int V_W = 6;
  localparam int D_W = 8;

  typedef struct {
    int hTot, vTot;
    int hsOff, hsUp, hsDown;
    int vsOff, vsUp, vsDown;
    int deOff, deUp, deDown, deFirst, deLast;
    logic [3:0] pol;
  } timing_t;

  typedef struct {
    logic hs, vs, de, pcHigh, run;
    logic [D_W-1:0] pix;
    logic [3:0] pol;
  } expect_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [D_W-1:0] pixIn = '0;
  timing_t cur;
  timing_t mS;
  int mRun, mH, mV;
  int phase = 0;
  expect_t q[$];
  int checks = 0;
  int fails = 0;
  logic pcSample;
  logic prevVs = 1'b0;
  logic seenHs = 1'b0;
  logic pixClk, hsyncOut, vsyncOut, deOut;
  logic [D_W-1:0] pixOut;

  always #2.5 clk = ~clk;

  tft_timing_gen #(.H_W(H_W), .V_W(V_W), .D_W(D_W)) u_tft_timing_gen (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable         (enable),
    .cfgHTotal      (H_W'(cur.hTot)),
    .cfgVTotal      (V_W'(cur.vTot)),
    .cfgHsOffset    (H_W'(cur.hsOff)),
    .cfgHsUp        (H_W'(cur.hsUp)),
    .cfgHsDown      (H_W'(cur.hsDown)),
    .cfgVsOffset    (H_W'(cur.vsOff)),
    .cfgVsUp        (V_W'(cur.vsUp)),
    .cfgVsDown      (V_W'(cur.vsDown)),
    .cfgDeOffset    (H_W'(cur.deOff)),
    .cfgDeUp        (H_W'(cur.deUp)),
    .cfgDeDown      (H_W'(cur.deDown)),
    .cfgDeFirstLine (V_W'(cur.deFirst)),
    .cfgDeLastLine  (V_W'(cur.deLast)),
    .cfgPolarity    (cur.pol),
    .pixIn          (pixIn),
    .pixClk         (pixClk),
    .hsyncOut       (hsyncOut),
    .vsyncOut       (vsyncOut),
    .deOut          (deOut),
    .pixOut         (pixOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: predicts the outputs visible after this edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mRun = 0; mH = 0; mV = 0;
      mS = '{default: 0};
      mS.pol = 4'b1110;
    end else begin
      expect_t e;
      bit hsA, vsA, deA;
      int pos;
      pos = mV * mS.hTot + mH;
      hsA = (mRun != 0) && (mH >= mS.hsOff + mS.hsUp) && (mH < mS.hsOff + mS.hsDown);
      vsA = (mRun != 0) && (pos >= mS.vsUp * mS.hTot + mS.vsOff) &&
            (pos < mS.vsDown * mS.hTot + mS.vsOff);
      deA = (mRun != 0) && (mH >= mS.deOff + mS.deUp) && (mH < mS.deOff + mS.deDown) &&
            (mV >= mS.deFirst) && (mV < mS.deLast);
      e.hs = mS.pol[1] ? hsA : !hsA;
      e.vs = mS.pol[2] ? vsA : !vsA;
      e.de = mS.pol[3] ? deA : !deA;
      e.pcHigh = (mRun != 0) ? !mS.pol[0] : mS.pol[0];
      e.run = (mRun != 0);
      e.pix = deA ? pixIn : '0;
      e.pol = mS.pol;
      q.push_back(e);
      if (!enable) begin
        mRun = 0; mH = 0; mV = 0;
      end else if (mRun == 0) begin
        mRun = 1; mH = 0; mV = 0; mS = cur;
      end else if (mH == mS.hTot - 1) begin
        mH = 0;
        if (mV == mS.vTot - 1) begin mV = 0; mS = cur; end
        else mV++;
      end else mH++;
    end
  end

  // monitor: high-phase clock sample, then compare at the falling edge
  initial begin
    forever begin
      @(posedge clk);
      #1 pcSample = pixClk;
      @(negedge clk);
      if (q.size() > 0) begin
        expect_t e;
        string ph;
        bit vsNow, hsNow;
        e = q.pop_front();
        ph = (phase == 1) ? " R8" : (phase == 2) ? " R6 R8" : (phase == 3) ? " R9" : "";
        check(hsyncOut == e.hs, {"R1 R2 hsync", ph}, hsyncOut, e.hs);
        check(vsyncOut == e.vs, {"R1 R3 vsync", ph}, vsyncOut, e.vs);
        check(deOut == e.de, {"R4 enable", ph}, deOut, e.de);
        check(pixOut == e.pix, {"R5 data", ph}, pixOut, e.pix);
        check(pcSample == e.pcHigh, {"R6 R7 pixclk", ph}, pcSample, e.pcHigh);
        vsNow = (vsyncOut == e.pol[2]);
        hsNow = (hsyncOut == e.pol[1]);
        if (e.run && prevVs && !vsNow)
          check(seenHs, "R10 vsync pulse without hsync", seenHs, 1);
        seenHs = vsNow ? (seenHs | hsNow) : 1'b0;
        prevVs = vsNow;
      end
    end
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pixIn = pixIn + 8'd37;
    end
  endtask

  initial begin
    cur = '{hTot: 20, vTot: 6, hsOff: 2, hsUp: 1, hsDown: 4,
            vsOff: 5, vsUp: 1, vsDown: 3,
            deOff: 6, deUp: 1, deDown: 15, deFirst: 2, deLast: 5, pol: 4'b1110};
    // reset state, R9
    repeat (3) @(negedge clk);
    check(hsyncOut == 1'b0, "R9 reset hsync", hsyncOut, 0);
    check(vsyncOut == 1'b0, "R9 reset vsync", vsyncOut, 0);
    check(deOut == 1'b0, "R9 reset enable", deOut, 0);
    check(pixOut == '0, "R9 reset data", pixOut, 0);
    @(posedge clk); #1;
    check(pixClk == 1'b0, "R9 reset pixclk high phase", pixClk, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cycles(6);                    // idle before enable, R9
    enable = 1'b1;
    cycles(2 * 120 + 30);         // two frames plus part of a third
    phase = 1;                    // mid-frame change, R8
    cur.hsUp = 0; cur.hsDown = 6;
    cur.deOff = 4; cur.deUp = 0; cur.deDown = 18;
    cur.deFirst = 1; cur.deLast = 6;
    cur.pol = 4'b0001;
    cycles(90);
    phase = 2;                    // new set and active-low polarity, R6
    cycles(2 * 120);
    phase = 3;
    enable = 1'b0;                // stop, R9
    cycles(10);
    phase = 0;
    cur = '{hTot: 7, vTot: 4, hsOff: 2, hsUp: 1, hsDown: 4,
            vsOff: 5, vsUp: 1, vsDown: 3,
            deOff: 0, deUp: 1, deDown: 9, deFirst: 0, deLast: 4, pol: 4'b1110};
    enable = 1'b1;
    cycles(3 * 28 + 5);
    enable = 1'b0;
    cycles(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule